// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a synchronous serial slave that gives a host read and write access to a small bank of configuration registers. Those registers feed a frequency synthesis core: a main control word, an auxiliary control word, a 32-bit frequency word and a 16-bit phase word. The serial clock, chip select, resync and data pins are brought into the system clock domain through synchronizer flops. All frame decoding runs on edges detected from the synchronized serial clock.

Each transfer opens with an 8-bit instruction. The instruction picks read or write and a register address, and then a fixed number of data bytes follows for that register. Writes land in shadow registers. A one-cycle `update` strobe copies every shadow register into the active register that drives the core. The host picks the bit order (MSB or LSB first) and the pin mode (read data shared on the bidirectional pin, or sent on a separate output pin) by writing bits of the main control word. Both choices are frozen at the start of each instruction. A resync input or a deasserted chip select drops any partial transfer and returns the port to waiting for an instruction. The auxiliary word carries a clock-multiplier field, and the block decodes that field into a multiplier value and a bypass flag.

Top module: `serial_cfg_port`

## Requirements
- R1: The instruction byte has read (1) or write (0) in bit 7 and the register address in bits 4:0. Data lengths are 4 bytes at address 0 (main control), 3 bytes at address 1 (auxiliary control), 4 bytes at address 2 (frequency word) and 2 bytes at address 3 (phase word). Every other address takes 1 byte: a write to it is discarded and a read of it returns zeros.
- R2: A completed write stores the data in the shadow register of its address. A later read of that address returns the shadow contents.
- R3: Active registers change only when `update` is high. On an accepted `update` each active register takes its shadow value in the next clock cycle.
- R4: An `update` that arrives while the data bytes of a write transfer are still being received is ignored, and the active registers keep their values.
- R5: Input bits are sampled on the rising serial clock edge, and read data bits change only after a falling edge. After reset the order is MSB first.
- R6: When bit 0 of the active main control word is 1, the whole transfer, instruction included, runs LSB first.
- R7: Bit order and pin mode are captured when an instruction byte begins. A commit during a transfer does not alter that transfer.
- R8: When bit 1 of the active main control word is 0, read data comes out on `sdio_out` with `sdio_oe` high. When that bit is 1, read data comes out on `sdo` with `sdo_oe` high, and `sdio_oe` stays low.
- R9: While `cs_n` is high both output enables are low and the bit counters reset. A partial transfer is discarded.
- R10: A high `resync` aborts the current transfer, and the port then waits for a new instruction byte while `cs_n` stays low.
- R11: `pll_mult` is bits 7:3 of the active auxiliary word. `pll_bypass` is 1 unless that value lies from 4 to 20 inclusive.
- R12: After reset all shadow and active registers are zero, `pll_bypass` is 1 and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| resync | input | 1 | Active-high transfer abort |
| sdio_in | input | 1 | Serial data input (pad input of the bidirectional pin) |
| update | input | 1 | Commit strobe, shadow to active |
| sdio_out | output | 1 | Read data toward the bidirectional pin |
| sdio_oe | output | 1 | Drive enable of the bidirectional pin |
| sdo | output | 1 | Read data on the separate output pin |
| sdo_oe | output | 1 | Drive enable of the separate output pin |
| ctrl_main_q | output | 32 | Active main control word (bit 0 LSB-first, bit 1 separate-output mode) |
| ctrl_aux_q | output | 32 | Active auxiliary control word (bits 31:24 read zero) |
| freq_word_q | output | 32 | Active frequency word |
| phase_word_q | output | 32 | Active phase word (bits 31:16 read zero) |
| pll_mult | output | 5 | Multiplier field decoded from the auxiliary word |
| pll_bypass | output | 1 | High when the multiplier field is outside 4..20 |

## Verification
The hardest situations to reach are the two where a commit lands in the middle of a transfer. For a write, the commit must be dropped. For a read, the commit must take effect but must not flip the bit order of the transfer already running. The stimulus first leaves a shadow register that differs from its active copy. It then pulses `update` at a chosen data bit inside a later transfer. A dropped commit then shows as an unchanged active port, and a wrongly applied order switch shows as a bit-reversed read value. The aborts are reached by cutting a frame after a few bits, using `resync` with chip select held low or by raising `cs_n`, and then running a full frame whose result must be clean.

// File: rtl/srp_pkg.sv
// Shared constants, phase type and register-map helpers for the serial
// configuration port. Assumes at most 2**ADDR_W addresses and registers no
// wider than DATA_W bits.
package srp_pkg;
    localparam int ADDR_W         = 5;
    localparam int DATA_W         = 32;
    localparam int INSTR_W        = 8;
    localparam int NUM_REGS       = 4;
    localparam int SYNC_STAGES    = 2;
    localparam int LSB_FIRST_BIT  = 0;
    localparam int THREE_WIRE_BIT = 1;
    localparam int PLL_LSB        = 3;
    localparam int PLL_W          = 5;
    localparam int PLL_MIN        = 4;
    localparam int PLL_MAX        = 20;
    localparam int CNT_W          = $clog2(DATA_W) + 1;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    // Data byte count that follows an instruction for a given address.
    function automatic int reg_bytes(input logic [ADDR_W-1:0] a);
        if (a == ADDR_W'(0)) return 4;
        if (a == ADDR_W'(1)) return 3;
        if (a == ADDR_W'(2)) return 4;
        if (a == ADDR_W'(3)) return 2;
        return 1;
    endfunction

    // Mask of the implemented bits of register idx.
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (b < 8 * reg_bytes(ADDR_W'(idx))) m[b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/srp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the inputs change slowly compared with clk.
module srp_sync #(
    parameter int                WIDTH   = 4,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/srp_engine.sv
// Serial frame engine. It decodes the instruction byte, shifts write data in
// on rising serial clock edges and read data out on falling edges, and issues
// a single-cycle write to the register bank. Assumes all inputs are already
// synchronous to clk, and a serial clock period of several clk cycles.
module srp_engine
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              resync_s,
    input  logic              din_s,
    input  logic              cfg_lsb,
    input  logic              cfg_3w,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              write_busy,
    output logic              dout,
    output logic              sdio_oe,
    output logic              sdo_oe
);
    localparam int RW_BIT = INSTR_W - 1;

    logic               sclk_d, rise, fall, abort;
    phase_e             phase;
    logic [CNT_W-1:0]   cnt, nbits;
    logic [INSTR_W-1:0] ir, ir_n;
    logic [DATA_W-1:0]  isr, isr_n, osr;
    logic               is_read, order_lsb, three_w, load_pend, rd_active;
    logic [ADDR_W-1:0]  addr_q;

    // Edge detection on the synchronized serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise  = sclk_s & ~sclk_d;
    assign fall  = ~sclk_s & sclk_d;
    assign abort = cs_n_s | resync_s;

    // Next values of the instruction and data input shifters.
    always_comb begin
        ir_n  = order_lsb ? {din_s, ir[INSTR_W-1:1]} : {ir[INSTR_W-2:0], din_s};
        isr_n = order_lsb ? {din_s, isr[DATA_W-1:1]} : {isr[DATA_W-2:0], din_s};
    end

    // Frame sequencing: instruction, data, done; abort on cs_n or resync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_INSTR;
            cnt       <= '0;
            nbits     <= '0;
            ir        <= '0;
            isr       <= '0;
            osr       <= '0;
            dout      <= 1'b0;
            is_read   <= 1'b0;
            addr_q    <= '0;
            order_lsb <= 1'b0;
            three_w   <= 1'b0;
            load_pend <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (phase == PH_INSTR && cnt == '0 && !rise) begin
                order_lsb <= cfg_lsb;
                three_w   <= cfg_3w;
            end
            if (abort) begin
                phase     <= PH_INSTR;
                cnt       <= '0;
                is_read   <= 1'b0;
                load_pend <= 1'b0;
            end else begin
                if (rise) begin
                    case (phase)
                        PH_INSTR: begin
                            ir <= ir_n;
                            if (cnt == CNT_W'(INSTR_W - 1)) begin
                                cnt       <= '0;
                                phase     <= PH_DATA;
                                is_read   <= ir_n[RW_BIT];
                                addr_q    <= ir_n[ADDR_W-1:0];
                                nbits     <= CNT_W'(8 * reg_bytes(ir_n[ADDR_W-1:0]));
                                isr       <= '0;
                                load_pend <= ir_n[RW_BIT];
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        PH_DATA: begin
                            if (!is_read) isr <= isr_n;
                            if (cnt == nbits - CNT_W'(1)) begin
                                phase <= PH_DONE;
                                if (!is_read) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= addr_q;
                                    wr_data <= order_lsb ? (isr_n >> (DATA_W - int'(nbits))) : isr_n;
                                end
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                        default: ;
                    endcase
                end
                if (load_pend) begin
                    load_pend <= 1'b0;
                    osr <= order_lsb ? rd_data : (rd_data << (DATA_W - int'(nbits)));
                end else if (fall && phase == PH_DATA && is_read) begin
                    dout <= order_lsb ? osr[0] : osr[DATA_W-1];
                    osr  <= order_lsb ? (osr >> 1) : (osr << 1);
                end
            end
        end
    end

    assign rd_addr    = addr_q;
    assign write_busy = (phase == PH_DATA) && !is_read;
    assign rd_active  = (phase == PH_DATA) && is_read && !abort;
    assign sdio_oe    = rd_active && !three_w;
    assign sdo_oe     = rd_active && three_w;

    // Chip select high returns the frame logic to its idle point (R9).
    assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (phase == PH_INSTR && cnt == '0 && !sdio_oe && !sdo_oe));

    // Resync returns the port to waiting for an instruction (R10).
    assert_resync_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resync_s |=> (phase == PH_INSTR && cnt == '0));

    // Bit order is frozen for the length of a data phase (R7).
    assert_order_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !abort) |=> (phase != PH_DATA || $stable(order_lsb)));

    // Read data changes only after a falling serial clock edge (R5).
    assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(dout));

    // A write to the bank is a single-cycle pulse (R2).
    assert_write_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/srp_regbank.sv
// Shadow and active register bank. Writes go to shadow copies trimmed to
// each register's width; a commit copies every shadow into its active copy
// unless a write transfer is still receiving data.
module srp_regbank
    import srp_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic                             update,
    input  logic                             write_busy,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  active
);
    logic              commit;
    logic [DATA_W-1:0] shadow_w [NUM_REGS];

    assign commit = update & ~write_busy;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = reg_mask(g);
        logic [DATA_W-1:0] shadow_r, active_r;

        // Capture a write addressed to this register.
        always_ff @(posedge clk) begin
            if (!rst_n)                               shadow_r <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))  shadow_r <= wr_data & MASK;
        end

        // Copy the shadow value on an accepted commit.
        always_ff @(posedge clk) begin
            if (!rst_n)      active_r <= '0;
            else if (commit) active_r <= shadow_r;
        end

        assign shadow_w[g] = shadow_r;
        assign active[g]   = active_r;
    end

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = shadow_w[i];
        end
    end

    // Without an update strobe the active registers hold (R3).
    assert_hold_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> $stable(active));

    // An update during a write data phase is dropped (R4).
    assert_update_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (update && write_busy) |=> $stable(active));
endmodule

// File: rtl/serial_cfg_port.sv
// Top of the serial configuration port: input synchronizers, frame engine,
// register bank and the clock-multiplier field decode. Assumes sclk runs at
// most at one eighth of clk and that the data input settles half a serial
// period before each rising edge.
module serial_cfg_port
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              resync,
    input  logic              sdio_in,
    input  logic              update,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [31:0]       ctrl_main_q,
    output logic [31:0]       ctrl_aux_q,
    output logic [31:0]       freq_word_q,
    output logic [31:0]       phase_word_q,
    output logic [PLL_W-1:0]  pll_mult,
    output logic              pll_bypass
);
    logic [3:0]                       raw, synced;
    logic                             dout, wr_en, write_busy;
    logic [ADDR_W-1:0]                rd_addr, wr_addr;
    logic [DATA_W-1:0]                rd_data, wr_data;
    logic [NUM_REGS-1:0][DATA_W-1:0]  active;

    assign raw = {sclk, cs_n, resync, sdio_in};

    srp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (synced)
    );

    srp_engine i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (synced[3]),
        .cs_n_s     (synced[2]),
        .resync_s   (synced[1]),
        .din_s      (synced[0]),
        .cfg_lsb    (active[0][LSB_FIRST_BIT]),
        .cfg_3w     (active[0][THREE_WIRE_BIT]),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .write_busy (write_busy),
        .dout       (dout),
        .sdio_oe    (sdio_oe),
        .sdo_oe     (sdo_oe)
    );

    srp_regbank i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .update     (update),
        .write_busy (write_busy),
        .rd_data    (rd_data),
        .active     (active)
    );

    assign sdio_out     = dout;
    assign sdo          = dout;
    assign ctrl_main_q  = active[0];
    assign ctrl_aux_q   = active[1];
    assign freq_word_q  = active[2];
    assign phase_word_q = active[3];

    // Decode the multiplier field; out-of-range values mean bypass.
    always_comb begin
        pll_mult   = active[1][PLL_LSB +: PLL_W];
        pll_bypass = (int'(pll_mult) < PLL_MIN) || (int'(pll_mult) > PLL_MAX);
    end

    // Only one output pin may be driven at a time (R8).
    assert_single_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe || sdio_oe) |-> (sdo_oe != sdio_oe));
endmodule

// File: tb/test_serial_cfg_port.sv
// Directed bench for serial_cfg_port: one task per scenario.
module test_serial_cfg_port;
    localparam int HALF     = 4;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst_n, sclk, cs_n, resync, sdio_in, update;
    logic sdio_out, sdio_oe, sdo, sdo_oe, pll_bypass;
    logic [31:0] ctrl_main_q, ctrl_aux_q, freq_word_q, phase_word_q;
    logic [4:0]  pll_mult;

    int n_chk = 0;
    int n_fail = 0;
    int oe_good = 0;
    int oe_bad = 0;

    always #10 clk = ~clk;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .resync(resync),
        .sdio_in(sdio_in), .update(update), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_main_q(ctrl_main_q), .ctrl_aux_q(ctrl_aux_q),
        .freq_word_q(freq_word_q), .phase_word_q(phase_word_q),
        .pll_mult(pll_mult), .pll_bypass(pll_bypass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_update();
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
    endtask

    // One serial bit: set data, sample read pin before the rise, then fall.
    task automatic bit_cycle(input logic d, input bit three, input bit rdph, output logic q);
        sdio_in = d;
        repeat (HALF) @(negedge clk);
        q = three ? sdo : sdio_out;
        if (rdph) begin
            if (three ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe)) oe_good++;
            else oe_bad++;
        end
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_instr(input bit rd, input logic [4:0] a, input bit lsb, input bit three);
        logic [7:0] ins;
        logic q;
        ins = {rd, 2'b00, a};
        for (int i = 0; i < 8; i++) bit_cycle(ins[lsb ? i : 7 - i], three, 1'b0, q);
    endtask

    // A full frame; upd_at >= 0 pulses update before that data bit.
    task automatic xfer(input bit rd, input logic [4:0] a, input int nbytes, input logic [31:0] wv,
                        input bit lsb, input bit three, input int upd_at, output logic [31:0] rv);
        logic q;
        int nb;
        nb = nbytes * 8;
        rv = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        send_instr(rd, a, lsb, three);
        for (int i = 0; i < nb; i++) begin
            int idx;
            idx = lsb ? i : nb - 1 - i;
            if (i == upd_at) pulse_update();
            bit_cycle(wv[idx], three, rd, q);
            rv[idx] = q;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input int nb, input logic [31:0] v, input bit lsb, input bit three);
        logic [31:0] dummy;
        xfer(1'b0, a, nb, v, lsb, three, -1, dummy);
    endtask

    task automatic t_reset();
        chk("R12 main word", ctrl_main_q, 32'h0);
        chk("R12 aux word", ctrl_aux_q, 32'h0);
        chk("R12 freq word", freq_word_q, 32'h0);
        chk("R12 phase word", phase_word_q, 32'h0);
        chk("R12 bypass", {31'h0, pll_bypass}, 32'h1);
        chk("R12 enables", {30'h0, sdio_oe, sdo_oe}, 32'h0);
    endtask

    task automatic t_write_read();
        logic [31:0] r;
        wr(5'd1, 3, 32'h0012_3456, 1'b0, 1'b0);
        wr(5'd2, 4, 32'hDEAD_BEEF, 1'b0, 1'b0);
        wr(5'd3, 2, 32'h0000_BEEF, 1'b0, 1'b0);
        oe_good = 0; oe_bad = 0;
        xfer(1'b1, 5'd1, 3, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R2 R5 aux readback", r, 32'h0012_3456);
        xfer(1'b1, 5'd2, 4, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R1 R2 freq readback", r, 32'hDEAD_BEEF);
        xfer(1'b1, 5'd3, 2, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R1 phase readback", r, 32'h0000_BEEF);
        chk("R8 two-wire enable", oe_bad, 0);
        chk("R9 enables off after frame", {30'h0, sdio_oe, sdo_oe}, 32'h0);
    endtask

    task automatic t_double_buffer();
        chk("R3 freq before commit", freq_word_q, 32'h0);
        pulse_update();
        @(negedge clk);
        chk("R3 freq after commit", freq_word_q, 32'hDEAD_BEEF);
        chk("R3 aux after commit", ctrl_aux_q, 32'h0012_3456);
    endtask

    task automatic t_pll();
        int vals [4] = '{4, 20, 21, 3};
        for (int k = 0; k < 4; k++) begin
            wr(5'd1, 3, 32'(vals[k]) << 3, 1'b0, 1'b0);
            pulse_update();
            @(negedge clk);
            chk("R11 multiplier", {27'h0, pll_mult}, 32'(vals[k]));
            chk("R11 bypass", {31'h0, pll_bypass}, (vals[k] >= 4 && vals[k] <= 20) ? 32'h0 : 32'h1);
        end
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        wr(5'd9, 1, 32'h0000_00FF, 1'b0, 1'b0);
        xfer(1'b1, 5'd9, 1, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R1 unmapped reads zero", r, 32'h0);
        xfer(1'b1, 5'd3, 2, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R1 unmapped write harmless", r, 32'h0000_BEEF);
    endtask

    task automatic t_three_wire();
        logic [31:0] r;
        wr(5'd0, 4, 32'h0000_0002, 1'b0, 1'b0);
        pulse_update();
        oe_good = 0; oe_bad = 0;
        xfer(1'b1, 5'd2, 4, 32'h0, 1'b0, 1'b1, -1, r);
        chk("R8 three-wire read on sdo", r, 32'hDEAD_BEEF);
        chk("R8 three-wire enables", oe_bad, 0);
        chk("R8 three-wire enable seen", {31'h0, oe_good == 32}, 32'h1);
        wr(5'd0, 4, 32'h0, 1'b0, 1'b1);
        pulse_update();
        @(negedge clk);
        chk("R8 back to two-wire", ctrl_main_q, 32'h0);
    endtask

    task automatic t_lsb();
        logic [31:0] r;
        wr(5'd0, 4, 32'h0000_0001, 1'b0, 1'b0);
        pulse_update();
        wr(5'd3, 2, 32'h0000_1234, 1'b1, 1'b0);
        xfer(1'b1, 5'd3, 2, 32'h0, 1'b1, 1'b0, -1, r);
        chk("R6 LSB-first readback", r, 32'h0000_1234);
        pulse_update();
        @(negedge clk);
        chk("R6 LSB-first write committed", phase_word_q, 32'h0000_1234);
    endtask

    task automatic t_order_hold();
        logic [31:0] r;
        wr(5'd0, 4, 32'h0, 1'b1, 1'b0);
        xfer(1'b1, 5'd2, 4, 32'h0, 1'b1, 1'b0, 5, r);
        chk("R7 order kept across commit", r, 32'hDEAD_BEEF);
        chk("R7 commit during read applied", ctrl_main_q, 32'h0);
        xfer(1'b1, 5'd2, 4, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R7 new order on next frame", r, 32'hDEAD_BEEF);
    endtask

    task automatic t_update_blocked();
        logic [31:0] r;
        wr(5'd2, 4, 32'h0102_0304, 1'b0, 1'b0);
        xfer(1'b0, 5'd3, 2, 32'h0000_5555, 1'b0, 1'b0, 8, r);
        chk("R4 freq held during write", freq_word_q, 32'hDEAD_BEEF);
        chk("R4 phase held during write", phase_word_q, 32'h0000_1234);
        pulse_update();
        @(negedge clk);
        chk("R4 later commit freq", freq_word_q, 32'h0102_0304);
        chk("R4 later commit phase", phase_word_q, 32'h0000_5555);
    endtask

    task automatic t_resync();
        logic [31:0] r;
        logic q;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        send_instr(1'b0, 5'd1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) bit_cycle(1'b1, 1'b0, 1'b0, q);
        resync = 1'b1;
        repeat (HALF) @(negedge clk);
        resync = 1'b0;
        repeat (HALF) @(negedge clk);
        send_instr(1'b0, 5'd1, 1'b0, 1'b0);
        for (int i = 0; i < 24; i++) bit_cycle(32'h00A0B0 >> (23 - i), 1'b0, 1'b0, q);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        xfer(1'b1, 5'd1, 3, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R10 frame after resync", r, 32'h0000_A0B0);
    endtask

    task automatic t_cs_abort();
        logic [31:0] r;
        logic q;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, 1'b0, 1'b0, q);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        chk("R9 enables off while deselected", {30'h0, sdio_oe, sdo_oe}, 32'h0);
        xfer(1'b1, 5'd3, 2, 32'h0, 1'b0, 1'b0, -1, r);
        chk("R9 clean frame after abort", r, 32'h0000_5555);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; resync = 1'b0; sdio_in = 1'b0; update = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write_read();
        t_double_buffer();
        t_pll();
        t_unmapped();
        t_three_wire();
        t_lsb();
        t_order_hold();
        t_update_blocked();
        t_resync();
        t_cs_abort();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule